// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block consumes a stream of 32-bit configuration words. It ignores everything until it has seen the pad word 0xFFFFFFFF directly followed by the sync word 0xAA995566. After that, it reads each word as a packet header or as payload. A type-1 header names a target register and a short word count. A type-2 header carries only a long word count and reuses the register chosen by the most recent type-1 write header. Payload words are routed into a small register set: a command register, a frame address register and a device identity check.

Words aimed at the frame-data input register leave the block on a separate output strobe. Each one is tagged with the frame index and word offset it belongs to. The tag steps forward by itself with every such word, so a stream that loads the frame address once covers consecutive frames in order. A reset-CRC command produces a single-cycle pulse. An identity word that differs from the expected value raises a sticky flag, and from then on no frame data is forwarded. Malformed headers raise a sticky decode error.

Top module: `cfg_stream_decoder`

## Requirements
- R1: No word is decoded until 0xFFFFFFFF is accepted directly followed by 0xAA995566. `synced` rises in the cycle after the sync word is accepted. A repeated 0xFFFFFFFF keeps the hunt armed, and any other word disarms it. Words accepted before sync change no output.
- R2: A type-1 header has bits [31:29]=001, opcode [28:27]=10 for write, register address [17:13] and word count [10:0]. It routes the next count words to that register. Address 0x04 is the command register, and `last_cmd` shows each command word in the cycle after it is accepted.
- R3: A command word equal to 0x00000007 raises `crc_reset` for exactly one cycle, in the cycle after acceptance. Any other command value leaves it low.
- R4: A payload word written to address 0x01 loads the frame index from the low bits of the word and clears the word offset. The next forwarded frame word carries that index and offset 0.
- R5: Each payload word written to address 0x02 appears on `frame_data` with `frame_valid` high in the cycle after acceptance. It is tagged with the frame index and offset current at that time.
- R6: The offset rises by one for each forwarded frame word. After offset FRAME_WORDS-1, the offset returns to 0 and the frame index rises by one.
- R7: A type-1 write header with count 0 only selects a register. A following type-2 header (bits [31:29]=010, opcode [28:27]=10, count [26:0]) routes count payload words to that register.
- R8: A type-2 header with no earlier type-1 write selection since reset, or a header whose bits [31:29] are neither 001 nor 010, sets `decode_error`. The flag stays set until reset.
- R9: The type-1 no-op word 0x20000000, seen where a header is expected, is consumed with no effect, and the following word is read as a header.
- R10: A payload word written to address 0x0E that differs from EXPECTED_ID sets `id_mismatch`, which stays set until reset. After that, no frame word is forwarded. A matching word leaves the flag low.
- R11: While `rst_n` is low at a clock edge, all outputs go to zero. `in_ready` is low during reset and high from the first edge after reset is released.
- R12: A word is consumed only in a cycle where `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 32 | Configuration word |
| in_ready | output | 1 | Decoder accepts a word this cycle |
| synced | output | 1 | Sync pattern has been found |
| frame_valid | output | 1 | A frame word is presented |
| frame_data | output | 32 | Forwarded frame word |
| frame_index | output | FIDX_W | Frame index tag of the forwarded word |
| frame_offset | output | clog2(FRAME_WORDS) | Word offset tag inside the frame |
| last_cmd | output | 32 | Most recent command register value |
| crc_reset | output | 1 | One-cycle reset-CRC pulse |
| id_mismatch | output | 1 | Sticky identity mismatch |
| decode_error | output | 1 | Sticky malformed-header flag |

## Verification
Two things can land on the same clock edge: forwarding a frame word and rolling the frame address over to the next frame. This happens when the last word of a frame is accepted. A type-2 burst of six frame words is started from a loaded index of 5 with four-word frames, so the crossing falls in the middle of the burst. The bench judges the crossing by the tags on the fourth and fifth forwarded words (index 5 offset 3, then index 6 offset 0), with no gap in `frame_valid`. The same table also runs a command burst whose last payload word is the reset-CRC value and is followed at once by a no-op header. This checks that the end of a payload count and the next header decode on adjacent edges, with a single pulse.

// File: rtl/cfg_pkg.sv
// Shared constants and helpers for the configuration stream decoder.
// Assumes 32-bit words and 5-bit register addresses.
package cfg_pkg;
    localparam logic [31:0] PAD_WORD  = 32'hFFFF_FFFF;
    localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
    localparam logic [31:0] CMD_RCRC  = 32'h0000_0007;

    localparam logic [4:0] RA_FAR  = 5'h01;
    localparam logic [4:0] RA_FDRI = 5'h02;
    localparam logic [4:0] RA_CMD  = 5'h04;
    localparam logic [4:0] RA_ID   = 5'h0E;

    localparam logic [2:0] HT_SHORT = 3'b001;
    localparam logic [2:0] HT_LONG  = 3'b010;
    localparam logic [1:0] OP_NOP   = 2'b00;
    localparam logic [1:0] OP_WR    = 2'b10;

    typedef enum logic [1:0] {
        HUNT_IDLE = 2'd0,
        HUNT_PAD  = 2'd1,
        HUNT_LOCK = 2'd2
    } hunt_t;

    function automatic logic [2:0] hdr_kind(input logic [31:0] w);
        return w[31:29];
    endfunction

    function automatic logic [1:0] hdr_op(input logic [31:0] w);
        return w[28:27];
    endfunction
endpackage

// File: rtl/cfg_sync_hunter.sv
// Sync hunter: looks for the pad word directly followed by the sync word.
// Once locked it stays locked until reset. Assumes one word per accepted cycle.
module cfg_sync_hunter
    import cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic [31:0] word,
    output logic        locked
);
    hunt_t st_q;

    // Advance the hunt on every word accepted before lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= HUNT_IDLE;
        end else if (take) begin
            case (st_q)
                HUNT_IDLE: if (word == PAD_WORD) st_q <= HUNT_PAD;
                HUNT_PAD: begin
                    if (word == SYNC_WORD)     st_q <= HUNT_LOCK;
                    else if (word != PAD_WORD) st_q <= HUNT_IDLE;
                end
                default:   st_q <= HUNT_LOCK;
            endcase
        end
    end

    assign locked = (st_q == HUNT_LOCK);
endmodule

// File: rtl/cfg_pkt_parser.sv
// Packet parser: turns header words into a register select and a payload
// count, then presents each payload word as a write strobe. Assumes words
// are only offered after sync lock.
module cfg_pkt_parser
    import cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic [31:0] word,
    output logic        wr_en,
    output logic [4:0]  wr_addr,
    output logic [31:0] wr_data,
    output logic        err
);
    localparam int CNT_W = 27;

    logic             in_pay_q;
    logic [CNT_W-1:0] left_q;
    logic [4:0]       sel_q;
    logic             sel_ok_q;
    logic             err_q;

    // Present the current payload word as a register write.
    always_comb begin
        wr_en   = take && in_pay_q;
        wr_addr = sel_q;
        wr_data = word;
    end

    // Header decode, payload counting and sticky error tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pay_q <= 1'b0;
            left_q   <= '0;
            sel_q    <= '0;
            sel_ok_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (take) begin
            if (in_pay_q) begin
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) in_pay_q <= 1'b0;
            end else begin
                case (hdr_kind(word))
                    HT_SHORT: begin
                        if (hdr_op(word) == OP_WR) begin
                            sel_q    <= word[17:13];
                            sel_ok_q <= 1'b1;
                            left_q   <= CNT_W'(word[10:0]);
                            in_pay_q <= (word[10:0] != 11'd0);
                        end else if (hdr_op(word) != OP_NOP) begin
                            err_q <= 1'b1;
                        end
                    end
                    HT_LONG: begin
                        if (!sel_ok_q || hdr_op(word) != OP_WR) begin
                            err_q <= 1'b1;
                        end else begin
                            left_q   <= word[26:0];
                            in_pay_q <= (word[26:0] != 27'd0);
                        end
                    end
                    default: err_q <= 1'b1;
                endcase
            end
        end
    end

    assign err = err_q;
endmodule

// File: rtl/cfg_reg_router.sv
// Register router: applies payload writes to the command register, the
// frame address and the identity check, and forwards frame-data writes
// with their frame index/offset tag. FRAME_WORDS must be at least 2.
module cfg_reg_router
    import cfg_pkg::*;
#(
    parameter int          FRAME_WORDS = 4,
    parameter int          FIDX_W      = 16,
    parameter logic [31:0] EXPECTED_ID = 32'h01C1_0093,
    localparam int         OFF_W       = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic              frame_valid,
    output logic [31:0]       frame_data,
    output logic [FIDX_W-1:0] frame_index,
    output logic [OFF_W-1:0]  frame_offset,
    output logic [31:0]       last_cmd,
    output logic              crc_reset,
    output logic              id_mismatch
);
    logic [FIDX_W-1:0] idx_q;
    logic [OFF_W-1:0]  off_q;
    logic              at_end;
    logic              fwd;
    logic              bad_id_q;

    // Detect the last word position of a frame; cheaper when a power of two.
    generate
        if (FRAME_WORDS == (1 << OFF_W)) begin : g_pow2
            assign at_end = &off_q;
        end else begin : g_gen
            assign at_end = (off_q == OFF_W'(FRAME_WORDS - 1));
        end
    endgenerate

    assign fwd = wr_en && (wr_addr == RA_FDRI) && !bad_id_q;

    // Frame address: load on a frame-address write, step on forwarded data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            off_q <= '0;
        end else if (wr_en && wr_addr == RA_FAR) begin
            idx_q <= wr_data[FIDX_W-1:0];
            off_q <= '0;
        end else if (fwd) begin
            if (at_end) begin
                off_q <= '0;
                idx_q <= idx_q + 1'b1;
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    // Forwarded frame word and its tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid  <= 1'b0;
            frame_data   <= '0;
            frame_index  <= '0;
            frame_offset <= '0;
        end else begin
            frame_valid <= fwd;
            if (fwd) begin
                frame_data   <= wr_data;
                frame_index  <= idx_q;
                frame_offset <= off_q;
            end
        end
    end

    // Command register and the reset-CRC pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cmd  <= '0;
            crc_reset <= 1'b0;
        end else begin
            crc_reset <= wr_en && (wr_addr == RA_CMD) && (wr_data == CMD_RCRC);
            if (wr_en && wr_addr == RA_CMD) last_cmd <= wr_data;
        end
    end

    // Sticky identity mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_id_q <= 1'b0;
        end else if (wr_en && wr_addr == RA_ID && wr_data != EXPECTED_ID) begin
            bad_id_q <= 1'b1;
        end
    end

    assign id_mismatch = bad_id_q;
endmodule

// File: rtl/cfg_stream_decoder.sv
// Top of the configuration packet stream decoder: sync hunt, packet parse,
// register routing and frame-address stepping. Input words are taken
// whenever in_valid is high out of reset; outputs are registered.
module cfg_stream_decoder #(
    parameter int          FRAME_WORDS = 4,
    parameter int          FIDX_W      = 16,
    parameter logic [31:0] EXPECTED_ID = 32'h01C1_0093,
    localparam int         OFF_W       = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              synced,
    output logic              frame_valid,
    output logic [31:0]       frame_data,
    output logic [FIDX_W-1:0] frame_index,
    output logic [OFF_W-1:0]  frame_offset,
    output logic [31:0]       last_cmd,
    output logic              crc_reset,
    output logic              id_mismatch,
    output logic              decode_error
);
    logic        ready_q;
    logic        take;
    logic        locked;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;

    // Ready comes up one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign in_ready = ready_q;
    assign take     = in_valid && ready_q;
    assign synced   = locked;

    cfg_sync_hunter u_hunt (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take && !locked),
        .word   (in_data),
        .locked (locked)
    );

    cfg_pkt_parser u_parse (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take && locked),
        .word    (in_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .err     (decode_error)
    );

    cfg_reg_router #(
        .FRAME_WORDS (FRAME_WORDS),
        .FIDX_W      (FIDX_W),
        .EXPECTED_ID (EXPECTED_ID)
    ) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .frame_valid  (frame_valid),
        .frame_data   (frame_data),
        .frame_index  (frame_index),
        .frame_offset (frame_offset),
        .last_cmd     (last_cmd),
        .crc_reset    (crc_reset),
        .id_mismatch  (id_mismatch)
    );
endmodule

// File: rtl/cfg_stream_decoder_chk.sv
// Property checker for cfg_stream_decoder, attached by bind. Sees top ports only.
module cfg_stream_decoder_chk #(
    parameter int FRAME_WORDS = 4,
    parameter int FIDX_W      = 16,
    localparam int OFF_W      = $clog2(FRAME_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              synced,
    input logic              frame_valid,
    input logic [FIDX_W-1:0] frame_index,
    input logic [OFF_W-1:0]  frame_offset,
    input logic              crc_reset,
    input logic              id_mismatch,
    input logic              decode_error
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(FRAME_WORDS - 1);

    // R1: nothing leaves the block before lock
    a_r1_quiet_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> (!frame_valid && !crc_reset));

    // R1: lock is kept until reset
    a_r1_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        synced |=> synced);

    // R3: reset-CRC is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        crc_reset |=> !crc_reset);

    // R6: back-to-back frame words step the tag by one and wrap at the frame end
    a_r6_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && $past(frame_valid)) |->
        (($past(frame_offset) == LAST_OFF)
            ? (frame_offset == '0 && frame_index == $past(frame_index) + 1'b1)
            : (frame_offset == $past(frame_offset) + 1'b1 && frame_index == $past(frame_index))));

    // R8: decode error is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        decode_error |=> decode_error);

    // R10: mismatch is sticky and blocks frame forwarding
    a_r10_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        id_mismatch |=> id_mismatch);
    a_r10_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
        id_mismatch |=> !frame_valid);

    // R11: ready stays up once out of reset
    a_r11_ready_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);
endmodule

bind cfg_stream_decoder cfg_stream_decoder_chk #(
    .FRAME_WORDS (FRAME_WORDS),
    .FIDX_W      (FIDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .synced       (synced),
    .frame_valid  (frame_valid),
    .frame_index  (frame_index),
    .frame_offset (frame_offset),
    .crc_reset    (crc_reset),
    .id_mismatch  (id_mismatch),
    .decode_error (decode_error)
);

// File: tb/tb_cfg_stream_decoder.sv
`timescale 1ns/1ps
module tb_cfg_stream_decoder;
    localparam int FW   = 4;
    localparam int FIW  = 16;
    localparam int OW   = $clog2(FW);
    localparam int NVEC = 27;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [31:0]    in_data = '0;
    logic           in_ready, synced, frame_valid, crc_reset, id_mismatch, decode_error;
    logic [31:0]    frame_data, last_cmd;
    logic [FIW-1:0] frame_index;
    logic [OW-1:0]  frame_offset;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_stream_decoder #(.FRAME_WORDS(FW), .FIDX_W(FIW), .EXPECTED_ID(32'h01C1_0093)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .synced(synced), .frame_valid(frame_valid),
        .frame_data(frame_data), .frame_index(frame_index), .frame_offset(frame_offset),
        .last_cmd(last_cmd), .crc_reset(crc_reset), .id_mismatch(id_mismatch),
        .decode_error(decode_error)
    );

    typedef struct packed {
        logic [31:0] w;
        logic        sy;
        logic        fv;
        logic [7:0]  idx;
        logic [3:0]  off;
        logic [31:0] cmd;
        logic        crc;
    } vec_t;

    // word, synced, frame_valid, index, offset, last_cmd, crc_reset (after the edge)
    localparam vec_t VECS [NVEC] = '{
        '{32'h3000_8001, 1'b0, 1'b0, 8'd0, 4'd0, 32'h0, 1'b0}, // R1 header before sync
        '{32'h0000_0007, 1'b0, 1'b0, 8'd0, 4'd0, 32'h0, 1'b0}, // R1 ignored
        '{32'hFFFF_FFFF, 1'b0, 1'b0, 8'd0, 4'd0, 32'h0, 1'b0},
        '{32'h1111_1111, 1'b0, 1'b0, 8'd0, 4'd0, 32'h0, 1'b0}, // R1 disarm
        '{32'hAA99_5566, 1'b0, 1'b0, 8'd0, 4'd0, 32'h0, 1'b0}, // R1 lone sync word
        '{32'hFFFF_FFFF, 1'b0, 1'b0, 8'd0, 4'd0, 32'h0, 1'b0},
        '{32'hFFFF_FFFF, 1'b0, 1'b0, 8'd0, 4'd0, 32'h0, 1'b0}, // R1 repeated pad
        '{32'hAA99_5566, 1'b1, 1'b0, 8'd0, 4'd0, 32'h0, 1'b0}, // R1 lock
        '{32'h3000_8001, 1'b1, 1'b0, 8'd0, 4'd0, 32'h0, 1'b0}, // R2 cmd header
        '{32'h0000_0007, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b1}, // R2 R3 pulse
        '{32'h2000_0000, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b0}, // R9 no-op, R3 pulse ends
        '{32'h3001_C001, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b0}, // R10 id header
        '{32'h01C1_0093, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b0}, // R10 match
        '{32'h3000_2001, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b0}, // R4 header
        '{32'h0000_0005, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b0}, // R4 index 5
        '{32'h3000_4000, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b0}, // R7 select only
        '{32'h5000_0006, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b0}, // R7 long count 6
        '{32'hA000_0000, 1'b1, 1'b1, 8'd5, 4'd0, 32'h7, 1'b0}, // R4 R5
        '{32'hA000_0001, 1'b1, 1'b1, 8'd5, 4'd1, 32'h7, 1'b0}, // R6
        '{32'hA000_0002, 1'b1, 1'b1, 8'd5, 4'd2, 32'h7, 1'b0}, // R6
        '{32'hA000_0003, 1'b1, 1'b1, 8'd5, 4'd3, 32'h7, 1'b0}, // R6 frame end
        '{32'hA000_0004, 1'b1, 1'b1, 8'd6, 4'd0, 32'h7, 1'b0}, // R6 rollover
        '{32'hA000_0005, 1'b1, 1'b1, 8'd6, 4'd1, 32'h7, 1'b0}, // R7 last of burst
        '{32'h3000_8002, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b0}, // R2 count 2
        '{32'h0000_0003, 1'b1, 1'b0, 8'd0, 4'd0, 32'h3, 1'b0}, // R3 no pulse
        '{32'h0000_0007, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b1}, // R3 pulse
        '{32'h2000_0000, 1'b1, 1'b0, 8'd0, 4'd0, 32'h7, 1'b0}  // R9 header after count
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one word for one edge, then sample at the following falling edge.
    task automatic put(input logic v, input logic [31:0] w);
        in_valid = v;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic lock();
        put(1'b1, 32'hFFFF_FFFF);
        put(1'b1, 32'hAA99_5566);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        // R11 reset state and ready during reset
        repeat (2) @(negedge clk);
        check(!in_ready && !synced && !frame_valid && last_cmd == 0 && !crc_reset
              && !id_mismatch && !decode_error, "R11 reset state",
              {32'd0, last_cmd}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready, "R11 ready after reset", {63'd0, in_ready}, 64'd1);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            put(1'b1, VECS[i].w);
            check(synced == VECS[i].sy, "R1 synced", {63'd0, synced}, {63'd0, VECS[i].sy});
            check(frame_valid == VECS[i].fv && (!VECS[i].fv ||
                  (frame_data == VECS[i].w && frame_index == FIW'(VECS[i].idx)
                   && frame_offset == OW'(VECS[i].off))),
                  "R5 R6 frame word/tag",
                  {15'd0, frame_valid, frame_index, 14'd0, frame_offset},
                  {15'd0, VECS[i].fv, 8'd0, VECS[i].idx, 12'd0, VECS[i].off});
            check(last_cmd == VECS[i].cmd && crc_reset == VECS[i].crc, "R2 R3 cmd/pulse",
                  {31'd0, crc_reset, last_cmd}, {31'd0, VECS[i].crc, VECS[i].cmd});
            check(!decode_error && !id_mismatch, "R9 R10 clean flags",
                  {62'd0, decode_error, id_mismatch}, 64'd0);
        end

        // R12: word with in_valid low is not consumed
        do_reset();
        lock();
        put(1'b1, 32'h3000_8001);
        put(1'b0, 32'h0000_0007);
        check(!crc_reset && last_cmd == 0, "R12 invalid word ignored", {32'd0, last_cmd}, 64'd0);
        put(1'b1, 32'h0000_0004);
        check(last_cmd == 32'h4, "R12 next valid word is payload", {32'd0, last_cmd}, 64'h4);

        // R8: long header without selection
        do_reset();
        lock();
        put(1'b1, 32'h5000_0003);
        check(decode_error, "R8 long header unselected", {63'd0, decode_error}, 64'd1);
        put(1'b1, 32'h3000_8001);
        check(decode_error, "R8 sticky", {63'd0, decode_error}, 64'd1);

        // R8: unknown header kind
        do_reset();
        lock();
        put(1'b1, 32'h6000_0000);
        check(decode_error, "R8 unknown kind", {63'd0, decode_error}, 64'd1);

        // R10: mismatched identity blocks frame words
        do_reset();
        lock();
        put(1'b1, 32'h3001_C001);
        put(1'b1, 32'hDEAD_BEEF);
        check(id_mismatch, "R10 mismatch raised", {63'd0, id_mismatch}, 64'd1);
        put(1'b1, 32'h3000_4003);
        for (int k = 0; k < 3; k++) begin
            put(1'b1, 32'hC000_0000 + 32'(k));
            check(!frame_valid && id_mismatch, "R10 frame word blocked",
                  {62'd0, frame_valid, id_mismatch}, 64'd1);
        end

        // R11: reset clears flags and drops ready
        rst_n = 1'b0;
        @(negedge clk);
        check(!in_ready && !id_mismatch && !synced, "R11 reset clears",
              {61'd0, in_ready, id_mismatch, synced}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end
endmodule